// File: doc/BRIEF.md
# AES Middle-Round Vector Execution Unit

This unit carries out a single non-final round of AES encryption on a 128-bit state with a 128-bit round key. The state bytes are first rotated row by row, then each byte passes through the AES substitution box, then each four-byte column is mixed over GF(2^8). The mixed state is XORed with the round key. The unit has no last-round variant: every result includes the column mix. Key schedule work and decryption are left to other logic.

The 128-bit round result goes into the low lane of a wider vector destination, 256 bits by default. A per-operation mode bit decides what happens to the upper lane. In merge mode the upper lane keeps the prior destination value supplied with the operation. In zeroing mode the upper lane is cleared.

Operations enter through a valid/ready issue port. Results leave through a valid/ready result port that is held in a single output register. An operation can be accepted in every cycle as long as the consumer keeps taking results.

Top module: `aes_round_unit`

## Requirements
- R1: Byte i of a 128-bit value sits in bits [8i+7:8i]. Byte i belongs to column i/4 and row i%4. The low 128 bits of the result are MixColumns(SubBytes(ShiftRows(state))) XOR key. ShiftRows sets output byte (row r, column c) to input byte (row r, column (c+r) mod 4). SubBytes is the standard AES S-box, for example 0x00 maps to 0x63 and 0xFF maps to 0x16. MixColumns multiplies each column by the circulant matrix {02,03,01,01} modulo x^8+x^4+x^3+x+1.
- R2: An all-zero state with an all-zero key gives 0x63 in every low byte. An all-0xFF state gives 0x16 XOR key byte in every low byte.
- R3: When `in_zero_upper` is 0 (merge mode), result bits above 127 equal the same bits of `in_dest`.
- R4: When `in_zero_upper` is 1 (zeroing mode), result bits above 127 are zero.
- R5: The published AES-128 example gives a fixed result. With the round-1 state 193de3bea0f4e22b9ac68d2ae9f84808 and the round-1 key a0fafe1788542cb123a339392a6c7605, the low result is a49c7ff2689f352b6b5bea43026a5049. All three values are written with byte 0 first.
- R6: `out_valid` rises on the clock edge that accepts an issue. It stays high, with `out_data` unchanged, until a cycle in which `out_ready` is high.
- R7: After a synchronous reset, `out_valid` is 0 and `in_ready` is 1.
- R8: While `out_valid` is 1 and `out_ready` is 0, `in_ready` is 0, no issue is accepted, and the held result is not replaced.
- R9: While `out_ready` stays high, one issue is accepted in every cycle and one result is delivered in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Issue request |
| in_ready | output | 1 | Unit can take an issue this cycle |
| in_state | input | 128 | Round input state |
| in_key | input | 128 | Round key |
| in_dest | input | VEC_W | Prior destination register value |
| in_zero_upper | input | 1 | 1: clear upper lane, 0: keep it |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | VEC_W | Merged destination value |

## Verification
Each result is due on the output register one clock edge after its issue handshake. It is then held for as long as the consumer stalls. The bench decides at each falling edge whether an issue and a delivery will occur at the next rising edge. It keeps one pending expected value, and checks that `out_valid` matches that pending state in every cycle. The held data is compared on the cycle it is taken, so any change during a stall shows up as a mismatch. The expected values come from a separate bench model of the round that uses a search-based S-box.

// File: rtl/aes_rnd_pkg.sv
// Package aes_rnd_pkg
// Purpose : shared widths and GF(2^8) helpers for the AES round unit.
// Assumes : AES field polynomial x^8+x^4+x^3+x+1; bytes are little-endian in a word.
package aes_rnd_pkg;

    localparam int BLK_W   = 128;
    localparam int N_BYTES = BLK_W / 8;
    localparam int N_COLS  = N_BYTES / 4;

    // Multiply by x in GF(2^8) with reduction.
    function automatic logic [7:0] gf_x2(input logic [7:0] a);
        gf_x2 = {a[6:0], 1'b0} ^ (a[7] ? 8'h1B : 8'h00);
    endfunction

    // General GF(2^8) multiply by shift and add.
    function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] acc;
        logic [7:0] sh;
        acc = 8'h00;
        sh  = a;
        for (int k = 0; k < 8; k++) begin
            if (b[k]) acc = acc ^ sh;
            sh = gf_x2(sh);
        end
        gf_mul = acc;
    endfunction

    // Multiplicative inverse as a^254 (0 maps to 0).
    function automatic logic [7:0] gf_inv(input logic [7:0] a);
        logic [7:0] p2, p3, p12, p15, p240, p252;
        p2   = gf_mul(a, a);
        p3   = gf_mul(p2, a);
        p12  = gf_mul(gf_mul(p3, p3), gf_mul(p3, p3));
        p15  = gf_mul(p12, p3);
        p240 = gf_mul(p15, p15);
        p240 = gf_mul(p240, p240);
        p240 = gf_mul(p240, p240);
        p240 = gf_mul(p240, p240);
        p252 = gf_mul(p240, p12);
        gf_inv = gf_mul(p252, p2);
    endfunction

    // Rotate a byte left by n bits.
    function automatic logic [7:0] rotl8(input logic [7:0] v, input int n);
        rotl8 = (v << n) | (v >> (8 - n));
    endfunction

    // AES substitution: field inverse followed by the affine map.
    function automatic logic [7:0] sbox(input logic [7:0] a);
        logic [7:0] b;
        b = gf_inv(a);
        sbox = b ^ rotl8(b, 1) ^ rotl8(b, 2) ^ rotl8(b, 3) ^ rotl8(b, 4) ^ 8'h63;
    endfunction

endpackage

// File: rtl/aes_rnd_shift.sv
// Module aes_rnd_shift
// Purpose : row rotation of the state; row r moves left by r columns.
// Assumes : byte index = 4*column + row, byte 0 in bits [7:0].
module aes_rnd_shift
    import aes_rnd_pkg::*;
(
    input  logic [BLK_W-1:0] src,
    output logic [BLK_W-1:0] dst
);

    // Each output byte is picked from column (c+r) mod N_COLS of the same row.
    for (genvar c = 0; c < N_COLS; c++) begin : g_col
        for (genvar r = 0; r < 4; r++) begin : g_row
            localparam int SRC_IDX = 4 * ((c + r) % N_COLS) + r;
            assign dst[8*(4*c+r) +: 8] = src[8*SRC_IDX +: 8];
        end
    end

endmodule

// File: rtl/aes_rnd_sub.sv
// Module aes_rnd_sub
// Purpose : byte substitution through the AES S-box on every byte.
// Assumes : S-box is computed as logic (inverse plus affine), no table.
module aes_rnd_sub
    import aes_rnd_pkg::*;
(
    input  logic [BLK_W-1:0] src,
    output logic [BLK_W-1:0] dst
);

    // One substitution instance per byte lane.
    for (genvar i = 0; i < N_BYTES; i++) begin : g_byte
        always_comb begin
            dst[8*i +: 8] = sbox(src[8*i +: 8]);
        end
    end

endmodule

// File: rtl/aes_rnd_mix.sv
// Module aes_rnd_mix
// Purpose : column mix with matrix {02,03,01,01} followed by key addition.
// Assumes : columns are four consecutive bytes, row 0 in the lowest byte.
module aes_rnd_mix
    import aes_rnd_pkg::*;
(
    input  logic [BLK_W-1:0] src,
    input  logic [BLK_W-1:0] key,
    output logic [BLK_W-1:0] dst
);

    // Per column: each row gets 2*own ^ 3*next ^ the two others, then the key byte.
    for (genvar c = 0; c < N_COLS; c++) begin : g_col
        logic [7:0] a [4];
        for (genvar r = 0; r < 4; r++) begin : g_in
            assign a[r] = src[8*(4*c+r) +: 8];
        end
        for (genvar r = 0; r < 4; r++) begin : g_out
            always_comb begin
                dst[8*(4*c+r) +: 8] = gf_x2(a[r])
                                    ^ gf_x2(a[(r+1)%4]) ^ a[(r+1)%4]
                                    ^ a[(r+2)%4]
                                    ^ a[(r+3)%4]
                                    ^ key[8*(4*c+r) +: 8];
            end
        end
    end

endmodule

// File: rtl/aes_round_unit.sv
// Module aes_round_unit
// Purpose : one non-final AES encryption round merged into a wide vector
//           destination, with a single registered result stage.
// Assumes : VEC_W > 128; synchronous active-low reset; the upper lane is
//           either kept from in_dest or cleared, chosen per operation.
module aes_round_unit
    import aes_rnd_pkg::*;
#(
    parameter int VEC_W = 256
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [BLK_W-1:0] in_state,
    input  logic [BLK_W-1:0] in_key,
    input  logic [VEC_W-1:0] in_dest,
    input  logic             in_zero_upper,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [VEC_W-1:0] out_data
);

    localparam int UP_W = VEC_W - BLK_W;

    logic [BLK_W-1:0] shifted;
    logic [BLK_W-1:0] substituted;
    logic [BLK_W-1:0] round_lo;
    logic [UP_W-1:0]  upper_next;
    logic             accept;

    aes_rnd_shift u_shift (.src(in_state),    .dst(shifted));
    aes_rnd_sub   u_sub   (.src(shifted),     .dst(substituted));
    aes_rnd_mix   u_mix   (.src(substituted), .key(in_key), .dst(round_lo));

    // Issue is possible when the output slot is empty or being drained.
    assign in_ready = !out_valid || out_ready;
    assign accept   = in_valid && in_ready;

    // Upper lane source: kept from the prior destination or cleared.
    always_comb begin
        upper_next = in_zero_upper ? '0 : in_dest[VEC_W-1:BLK_W];
    end

    // Output valid flag: set by an issue, cleared when taken without refill.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
        end else if (accept) begin
            out_valid <= 1'b1;
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end

    // Result register: loaded only on an accepted issue.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_data <= '0;
        end else if (accept) begin
            out_data <= {upper_next, round_lo};
        end
    end

    AST_VALID_AFTER_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> out_valid); // R6
    AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R6
    AST_NO_ISSUE_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready); // R8
    AST_UPPER_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && in_zero_upper) |=> (out_data[VEC_W-1:BLK_W] == '0)); // R4
    AST_UPPER_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !in_zero_upper) |=>
            (out_data[VEC_W-1:BLK_W] == $past(in_dest[VEC_W-1:BLK_W]))); // R3
    AST_DRAIN_WHEN_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (out_ready && !in_valid) |=> !out_valid); // R9

endmodule

// File: tb/aes_round_unit_tb_top.sv
// Bench for aes_round_unit: random and directed issues with random consumer
// stalls, checked against an independent model of one AES round.
module aes_round_unit_tb_top;

    localparam int VW = 256;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [127:0]  in_state = '0;
    logic [127:0]  in_key = '0;
    logic [VW-1:0] in_dest = '0;
    logic          in_zero_upper = 1'b0;
    logic          out_valid;
    logic          out_ready = 1'b0;
    logic [VW-1:0] out_data;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [7:0]    sb_tab [256];
    bit            pend = 1'b0;
    logic [VW-1:0] exp_q;
    bit            exp_vex;
    string         exp_tag;

    always #5 clk = ~clk;

    aes_round_unit #(.VEC_W(VW)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_state(in_state), .in_key(in_key), .in_dest(in_dest),
        .in_zero_upper(in_zero_upper), .out_valid(out_valid),
        .out_ready(out_ready), .out_data(out_data)
    );

    function automatic logic [7:0] m_mul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] p = 0;
        logic [7:0] x = a;
        for (int k = 0; k < 8; k++) begin
            if (b[k]) p ^= x;
            x = x[7] ? ((x << 1) ^ 8'h1B) : (x << 1);
        end
        return p;
    endfunction

    // S-box table: inverse by search, affine map written bit by bit.
    function automatic void build_sbox();
        for (int v = 0; v < 256; v++) begin
            logic [7:0] inv = 0;
            logic [7:0] s;
            for (int w = 1; w < 256; w++)
                if (m_mul(8'(v), 8'(w)) == 8'h01) inv = 8'(w);
            for (int i = 0; i < 8; i++)
                s[i] = inv[i] ^ inv[(i+4)%8] ^ inv[(i+5)%8] ^ inv[(i+6)%8]
                     ^ inv[(i+7)%8] ^ ((8'h63 >> i) & 1'b1);
            sb_tab[v] = s;
        end
    endfunction

    function automatic logic [127:0] m_round(input logic [127:0] st, input logic [127:0] k);
        logic [7:0] t [16];
        logic [127:0] o;
        for (int c = 0; c < 4; c++)
            for (int r = 0; r < 4; r++)
                t[4*c+r] = sb_tab[st[8*(4*((c+r)%4)+r) +: 8]];
        for (int c = 0; c < 4; c++)
            for (int r = 0; r < 4; r++)
                o[8*(4*c+r) +: 8] = m_mul(t[4*c+r], 8'h02) ^ m_mul(t[4*c+(r+1)%4], 8'h03)
                                  ^ t[4*c+(r+2)%4] ^ t[4*c+(r+3)%4] ^ k[8*(4*c+r) +: 8];
        return o;
    endfunction

    // Convert a hex string in byte-0-first order to the bit layout.
    function automatic logic [127:0] bo(input logic [127:0] v);
        logic [127:0] o;
        for (int i = 0; i < 16; i++) o[8*i +: 8] = v[8*(15-i) +: 8];
        return o;
    endfunction

    function automatic logic [VW-1:0] rnd_vec();
        logic [VW-1:0] v;
        for (int i = 0; i < VW/32; i++) v[32*i +: 32] = $urandom;
        return v;
    endfunction

    task automatic chk(input string req, input logic [VW-1:0] act, input logic [VW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One cycle: drive at the falling edge, then judge the next rising edge.
    task automatic cyc(input bit iv, input logic [127:0] st, input logic [127:0] k,
                       input logic [VW-1:0] d, input bit zu, input bit ordy,
                       input bit fixed, input logic [127:0] fixed_lo, input string tag);
        @(negedge clk);
        in_valid = iv; in_state = st; in_key = k; in_dest = d;
        in_zero_upper = zu; out_ready = ordy;
        #1;
        chk("R6 valid", VW'(out_valid), VW'(pend));
        if (out_valid && !out_ready) chk("R8 ready", VW'(in_ready), VW'(0));
        if (out_valid && out_ready && pend) begin
            chk(exp_tag, VW'(out_data[127:0]), VW'(exp_q[127:0]));
            chk(exp_vex ? "R4" : "R3", VW'(out_data[VW-1:128]), VW'(exp_q[VW-1:128]));
            pend = 1'b0;
        end
        if (in_valid && in_ready) begin
            exp_q   = {zu ? {(VW-128){1'b0}} : d[VW-1:128],
                       fixed ? fixed_lo : m_round(st, k)};
            exp_vex = zu;
            exp_tag = tag;
            pend    = 1'b1;
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(0, '0, '0, '0, 0, 1, 0, '0, "R1");
    endtask

    initial begin
        void'($urandom(32'h5EED_0A35));
        build_sbox();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R7 out_valid", VW'(out_valid), VW'(0));
        chk("R7 in_ready", VW'(in_ready), VW'(1));

        // R5: published round-1 example, merge mode
        cyc(1, bo(128'h193de3bea0f4e22b9ac68d2ae9f84808),
               bo(128'ha0fafe1788542cb123a339392a6c7605), rnd_vec(), 0, 1,
               1, bo(128'ha49c7ff2689f352b6b5bea43026a5049), "R5");
        idle(2);
        // R2: all-zero state and key, zeroing mode
        cyc(1, '0, '0, rnd_vec(), 1, 1, 1, {16{8'h63}}, "R2 zero");
        idle(1);
        // R2: all-ones state with a random key
        begin
            logic [127:0] k = rnd_vec()[127:0];
            cyc(1, {128{1'b1}}, k, rnd_vec(), 0, 1, 1, {16{8'h16}} ^ k, "R2 ones");
        end
        idle(1);
        // R9: back-to-back issues with the consumer always ready
        for (int i = 0; i < 8; i++) begin
            cyc(1, rnd_vec()[127:0], rnd_vec()[127:0], rnd_vec(), i[0], 1, 0, '0, "R9 R1");
            chk("R9 in_ready", VW'(in_ready), VW'(1));
        end
        idle(2);
        // R8: stall with a pending result and a competing issue
        cyc(1, rnd_vec()[127:0], rnd_vec()[127:0], rnd_vec(), 0, 0, 0, '0, "R8 R1");
        for (int i = 0; i < 3; i++)
            cyc(1, rnd_vec()[127:0], rnd_vec()[127:0], rnd_vec(), 1, 0, 0, '0, "R8 R1");
        idle(2);
        // R1 R3 R4: random traffic with random stalls
        for (int i = 0; i < 400; i++)
            cyc($urandom_range(0, 3) != 0, rnd_vec()[127:0], rnd_vec()[127:0], rnd_vec(),
                $urandom_range(0, 1) == 1, $urandom_range(0, 2) != 0, 0, '0, "R1");
        idle(3);
        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule